// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Threshold Flags

This block is a single-clock first-in first-out buffer that, besides the usual full and empty indications and per-request handshake pulses, raises two watermark flags. One flag, `prog_full`, warns a producer that the buffer is filling. The other, `prog_empty`, tells a consumer that the buffer is nearly drained. Both flags are derived from a registered occupancy count. Each flag also updates on the same clock edge as that count.

Each flag has its own mode parameter, and the mode sets where its thresholds come from. Bit 0 of the mode picks the source: a parameter when clear, an input port when set. Bit 1 picks the shape: a single level when clear, separate assert and negate levels when set. The two-level shape gives the flag hysteresis. When a mode takes its thresholds from ports, the ports are sampled on every edge, so a system may move a watermark while traffic is flowing.

Top module: `fifo_pflag`

## Requirements
- R1: While `rst_n` is low and after its release, the outputs are as follows until the first accepted request: `level` is 0, `empty` is 1, `full` is 0, `prog_empty` is 1, `prog_full` is 0 and all handshake outputs are 0.
- R2: `level` rises by one on an edge where a write is accepted and falls by one where a read is accepted. It is unchanged when both are accepted on the same edge. It never exceeds 2**AW.
- R3: Data comes out in the order it was accepted. A read accepted on an edge drives the word on `rd_data` after that edge, with `rd_ok` high for that one cycle.
- R4: A write is accepted only when `full` is 0. A write request made while full is ignored, stores nothing, and raises `wr_rej` for one cycle after the edge.
- R5: A read is accepted only when `empty` is 0. A read request made while empty leaves `level` unchanged and raises `rd_rej` for one cycle after the edge.
- R6: `wr_ok` is high for one cycle after each edge on which a write was accepted.
- R7: In the single-level modes (0 and 1), `prog_full` is 1 exactly when `level` is at or above the full threshold.
- R8: In the single-level modes (0 and 1), `prog_empty` is 1 exactly when `level` is at or below the empty threshold.
- R9: In the two-level modes (2 and 3), `prog_full` sets when `level` is at or above the full assert value. It clears when `level` is below the full negate value, and otherwise keeps its previous value.
- R10: In the two-level modes (2 and 3), `prog_empty` sets when `level` is at or below the empty assert value. It clears when `level` is above the empty negate value, and otherwise keeps its previous value.
- R11: The mode sources are as follows. Mode 0 uses the `*_SET_C` parameter. Mode 1 uses the `*_set` port. Mode 2 uses the `*_SET_C` and `*_CLR_C` parameters. Mode 3 uses the `*_set` and `*_clr` ports. Port values are taken at each edge, so a change moves the flag on the next edge even when `level` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Word from the last accepted read |
| full | output | 1 | Buffer holds 2**AW words |
| empty | output | 1 | Buffer holds no words |
| wr_ok | output | 1 | Previous-edge write accepted |
| wr_rej | output | 1 | Previous-edge write refused (full) |
| rd_ok | output | 1 | Previous-edge read accepted, `rd_data` valid |
| rd_rej | output | 1 | Previous-edge read refused (empty) |
| level | output | AW+1 | Registered occupancy |
| pf_set | input | AW+1 | Full threshold, or full assert level in mode 3 |
| pf_clr | input | AW+1 | Full negate level in mode 3 |
| pe_set | input | AW+1 | Empty threshold, or empty assert level in mode 3 |
| pe_clr | input | AW+1 | Empty negate level in mode 3 |
| prog_full | output | 1 | Programmable full flag |
| prog_empty | output | 1 | Programmable empty flag |

## Verification
The flag assertions assume ordered threshold pairs. The full negate level must sit below the full assert level, and the empty negate level must sit above the empty assert level. Under that assumption, a flag edge can be checked against the threshold in force on the edge before. The stimulus keeps to this by changing the port thresholds only in ordered pairs, and only between edges. Four copies of the block, one per mode, share the stimulus. Occupancy is swept through every threshold in both directions, including a step in which only the thresholds move.

// File: rtl/fifo_pflag.sv
module fifo_pflag #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int FULL_MODE = 3,
  parameter int EMPTY_MODE = 3,
  parameter int FULL_SET_C = 13,
  parameter int FULL_CLR_C = 9,
  parameter int EMPTY_SET_C = 3,
  parameter int EMPTY_CLR_C = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          wr_ok,
  output logic          wr_rej,
  output logic          rd_ok,
  output logic          rd_rej,
  output logic [AW:0]   level,
  input  logic [AW:0]   pf_set,
  input  logic [AW:0]   pf_clr,
  input  logic [AW:0]   pe_set,
  input  logic [AW:0]   pe_clr,
  output logic          prog_full,
  output logic          prog_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = AW + 1;
  localparam bit F_PORT = (FULL_MODE & 1) != 0;
  localparam bit F_RANGE = (FULL_MODE & 2) != 0;
  localparam bit E_PORT = (EMPTY_MODE & 1) != 0;
  localparam bit E_RANGE = (EMPTY_MODE & 2) != 0;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   lvl_nxt;
  logic [AW:0]   f_set, f_clr, e_set, e_clr;
  logic          w_go, r_go;

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign w_go  = wr_en && !full;
  assign r_go  = rd_en && !empty;
  assign lvl_nxt = level + CW'(w_go) - CW'(r_go);

  assign f_set = F_PORT ? pf_set : CW'(FULL_SET_C);
  assign f_clr = F_RANGE ? (F_PORT ? pf_clr : CW'(FULL_CLR_C)) : f_set;
  assign e_set = E_PORT ? pe_set : CW'(EMPTY_SET_C);
  assign e_clr = E_RANGE ? (E_PORT ? pe_clr : CW'(EMPTY_CLR_C)) : e_set;

  always_ff @(posedge clk) begin
    if (w_go) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      level <= '0;
      rd_data <= '0;
      wr_ok <= 1'b0;
      wr_rej <= 1'b0;
      rd_ok <= 1'b0;
      rd_rej <= 1'b0;
      prog_full <= 1'b0;
      prog_empty <= 1'b1;
    end else begin
      if (w_go) wptr <= wptr + 1'b1;
      if (r_go) begin
        rptr <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      level <= lvl_nxt;
      wr_ok <= w_go;
      wr_rej <= wr_en && full;
      rd_ok <= r_go;
      rd_rej <= rd_en && empty;
      if (lvl_nxt >= f_set) prog_full <= 1'b1;
      else if (lvl_nxt < f_clr) prog_full <= 1'b0;
      if (lvl_nxt <= e_set) prog_empty <= 1'b1;
      else if (lvl_nxt > e_clr) prog_empty <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_pflag_chk.sv
module fifo_pflag_chk #(
  parameter int AW = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        full,
  input logic        empty,
  input logic        wr_ok,
  input logic        wr_rej,
  input logic        rd_rej,
  input logic [AW:0] level,
  input logic [AW:0] f_set,
  input logic [AW:0] f_clr,
  input logic [AW:0] e_set,
  input logic [AW:0] e_clr,
  input logic        prog_full,
  input logic        prog_empty
);
  localparam int DEPTH = 1 << AW;

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> (wr_rej && !wr_ok));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> (rd_rej && $stable(level)));

  // R7 is covered too: a single level is a range with equal ends
  assert_pfull_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_full) |-> (level >= $past(f_set)));

  assert_pfull_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_full) |-> (level < $past(f_clr)));

  // R8 is covered too
  assert_pempty_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_empty) |-> (level <= $past(e_set)));

  assert_pempty_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_empty) |-> (level > $past(e_clr)));

  assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

bind fifo_pflag fifo_pflag_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .empty(empty), .wr_ok(wr_ok), .wr_rej(wr_rej), .rd_rej(rd_rej),
  .level(level), .f_set(f_set), .f_clr(f_clr), .e_set(e_set), .e_clr(e_clr),
  .prog_full(prog_full), .prog_empty(prog_empty)
);

// File: tb/fifo_pflag_tb.sv
`timescale 1ns/1ps
module fifo_pflag_tb;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW:0] pf_set = 5'd13, pf_clr = 5'd9, pe_set = 5'd3, pe_clr = 5'd5;

  logic [3:0] full_v, empty_v, wok_v, wrej_v, rok_v, rrej_v, pf_v, pe_v;
  logic [AW:0] lvl_v [4];
  logic [DW-1:0] rd_v [4];

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] sb [$];
  int mcnt = 0;
  bit mpf [4];
  bit mpe [4];

  always #2.5 clk = ~clk;

  for (genvar m = 0; m < 4; m++) begin : g_mode
    fifo_pflag #(
      .DW(DW), .AW(AW), .FULL_MODE(m), .EMPTY_MODE(m),
      .FULL_SET_C(m == 0 ? 12 : 13), .FULL_CLR_C(9),
      .EMPTY_SET_C(m == 0 ? 4 : 3), .EMPTY_CLR_C(5)
    ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_v[m]), .full(full_v[m]), .empty(empty_v[m]),
      .wr_ok(wok_v[m]), .wr_rej(wrej_v[m]), .rd_ok(rok_v[m]), .rd_rej(rrej_v[m]),
      .level(lvl_v[m]), .pf_set(pf_set), .pf_clr(pf_clr), .pe_set(pe_set),
      .pe_clr(pe_clr), .prog_full(pf_v[m]), .prog_empty(pe_v[m])
    );
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit we, input bit re, input logic [DW-1:0] wd);
    bit wacc, racc;
    int ncnt, fa, fn, ea, en;
    @(negedge clk);
    wr_en = we; rd_en = re; wr_data = wd;
    wacc = we && (mcnt < DEPTH);
    racc = re && (mcnt > 0);
    if (wacc) sb.push_back(wd);
    ncnt = mcnt + int'(wacc) - int'(racc);
    for (int m = 0; m < 4; m++) begin
      case (m)
        0: begin fa = 12; fn = 12; ea = 4; en = 4; end
        1: begin fa = pf_set; fn = pf_set; ea = pe_set; en = pe_set; end
        2: begin fa = 13; fn = 9; ea = 3; en = 5; end
        default: begin fa = pf_set; fn = pf_clr; ea = pe_set; en = pe_clr; end
      endcase
      if (ncnt >= fa) mpf[m] = 1; else if (ncnt < fn) mpf[m] = 0;
      if (ncnt <= ea) mpe[m] = 1; else if (ncnt > en) mpe[m] = 0;
    end
    mcnt = ncnt;
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0;
    for (int m = 0; m < 4; m++) begin
      check("R2 level", int'(lvl_v[m]), mcnt);
      check("R4 full", int'(full_v[m]), int'(mcnt == DEPTH));
      check("R5 empty", int'(empty_v[m]), int'(mcnt == 0));
      check("R6 wr_ok", int'(wok_v[m]), int'(wacc));
      check("R4 wr_rej", int'(wrej_v[m]), int'(we && !wacc));
      check("R3 rd_ok", int'(rok_v[m]), int'(racc));
      check("R5 rd_rej", int'(rrej_v[m]), int'(re && !racc));
      check(m[1] ? "R9 prog_full" : "R7 prog_full", int'(pf_v[m]), int'(mpf[m]));
      check(m[1] ? "R10 prog_empty" : "R8 prog_empty", int'(pe_v[m]), int'(mpe[m]));
    end
  endtask

  // monitor: pops the scoreboard on each read-data pulse (R3)
  always @(posedge clk) begin
    logic [DW-1:0] exp;
    #2;
    if (rst_n && rok_v[0]) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 order: actual %0d expected none (queue empty)", rd_v[0]);
      end else begin
        exp = sb.pop_front();
        for (int m = 0; m < 4; m++) check("R3 data order", int'(rd_v[m]), int'(exp));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 4; m++) begin mpf[m] = 0; mpe[m] = 1; end
    repeat (3) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      check("R1 level", int'(lvl_v[m]), 0);
      check("R1 empty", int'(empty_v[m]), 1);
      check("R1 full", int'(full_v[m]), 0);
      check("R1 prog_empty", int'(pe_v[m]), 1);
      check("R1 prog_full", int'(pf_v[m]), 0);
      check("R1 handshakes", int'({wok_v[m], wrej_v[m], rok_v[m], rrej_v[m]}), 0);
    end
    rst_n = 1'b1;

    // R7 R9 R11: rise through every threshold, then hit full
    for (int i = 0; i < DEPTH + 1; i++) step(1, 0, DW'(i + 1));
    step(1, 1, 8'hAA);              // R4: write refused at full, read accepted
    step(1, 0, 8'h55);
    step(1, 0, 8'h66);              // R4: refused again
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0);  // R8 R10 down, R5 at end
    step(1, 1, 8'h21);              // empty: write ok, read refused
    step(1, 1, 8'h22);              // R2: both accepted, level unchanged

    // R11: move port thresholds mid-run (ordered pairs)
    pf_set = 5'd6; pf_clr = 5'd4; pe_set = 5'd7; pe_clr = 5'd10;
    for (int i = 0; i < 7; i++) step(1, 0, DW'(8'h30 + i));
    pf_set = 5'd9; pf_clr = 5'd4; pe_set = 5'd9; pe_clr = 5'd12;
    step(0, 0, 0);                  // R11: flags move with level held
    step(0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 0, DW'(8'h40 + i));
    for (int i = 0; i < 5; i++) step(0, 1, 0);
    step(1, 1, 8'h50);
    for (int i = 0; i < 4; i++) step(1, 0, DW'(8'h60 + i));
    for (int i = 0; i < DEPTH; i++) step(i[0], 1, DW'(8'h70 + i));
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0);
    repeat (3) @(negedge clk);
    check("R3 queue drained", sb.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule